// File: doc/BRIEF.md
# Paced Sampling Controller for a Successive-Approximation Converter

This block sequences an external successive-approximation converter core. Software selects one of four operating modes: sleep, single-shot, handshake or free-running. In sleep nothing runs. A single-shot conversion drops back to sleep once its sample is in. In handshake mode each new conversion waits until software acknowledges the previous one. Free-running mode starts a new conversion at a fixed spacing, with no regard to software activity.

Each finished conversion puts its 12-bit result into a small sample store inside the block. The result is placed in the low bits of a 16-bit word. One programmed sample count sets both the usable depth of the store and the point at which the interrupt is raised. Software reads the words out one at a time through a read strobe. An acknowledge strobe empties the store and drops the interrupt. While the store is full, new samples overwrite the oldest ones and a sticky overflow flag is set. A separate setup strobe loads the channel, the sample count and the spacing between starts.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode status reads 0 (sleep), the interrupt, the overflow flag and the fill count read 0, and the channel, count and spacing settings are 0, 32 and 16. While the mode status is 0, `convStart` stays low.
- R2: Mode code 1 runs exactly one conversion. In the cycle after that conversion's `convDone`, the mode status reads 0 again, and no further conversion starts.
- R3: In mode code 2, every stored sample raises the interrupt. No conversion starts while the interrupt is high. After `irqClr`, the next conversion starts within a few cycles, without waiting for the programmed spacing.
- R4: In mode code 3, consecutive `convStart` pulses lie exactly the effective spacing apart. Sampling continues whether or not data is read, until another mode is written.
- R5: Each stored word carries the converter's 12-bit result in bits 11..0, and bits 15..12 are zero.
- R6: The interrupt rises in the same cycle that the fill count reaches the effective sample count. A count of 0, or a count above 32, is treated as 32.
- R7: A spacing below 16 is treated as 16. In any mode, two `convStart` pulses are never fewer than 16 cycles apart.
- R8: `irqClr` empties the store, resets both pointers and clears the interrupt and the overflow flag. A sample that finishes in the same cycle becomes the first entry of the emptied store.
- R9: If a sample arrives while the store holds the effective count, it replaces the oldest entry, the fill count stays put, the overflow flag goes high and stays high until `irqClr`, and reading restarts at the oldest surviving entry.
- R10: `convChan` carries the configured channel, and channel values above 13 are presented as 13.
- R11: `rdData` shows the entry at the read pointer. `rdEn` advances the pointer modulo the effective count and leaves the fill count unchanged.
- R12: Writing a mode aborts any conversion in flight. Its result is discarded, so the fill count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeWr | input | 1 | Strobe: load `modeSel` into the mode register |
| modeSel | input | 2 | Mode code: 0 sleep, 1 single-shot, 2 handshake, 3 free-running |
| setupWr | input | 1 | Strobe: load the channel, count and spacing |
| setupChan | input | 4 | Channel to convert (0..13) |
| setupCount | input | 6 | Sample count (store depth and interrupt point) |
| setupRate | input | 16 | Clock cycles between starts in free-running mode |
| rdEn | input | 1 | Advance the read pointer |
| irqClr | input | 1 | Acknowledge: empty the store, clear the interrupt and overflow |
| rdData | output | 16 | Sample word at the read pointer |
| fillCount | output | 6 | Number of stored samples |
| irq | output | 1 | Interrupt flag |
| overflow | output | 1 | Sticky flag: a sample overwrote an unread one |
| modeStatus | output | 2 | Current mode code |
| convStart | output | 1 | One-cycle pulse that starts a conversion |
| convChan | output | 4 | Channel for the conversion |
| convDone | input | 1 | Converter finished, result valid this cycle |
| convResult | input | 12 | Converter result |

## Verification
The hardest situation to reach is an acknowledge that lands in the same cycle as a finishing conversion, because the converter stub alone decides when `convDone` occurs. The bench watches the stub's done pulse at the falling edge and raises `irqClr` at that edge, so both reach the same rising edge. Store overflow with the oldest entries overwritten is reached by letting free-running mode run past the programmed count under seeded random spacings and counts. The bench stops the run one cycle after a done pulse and then reads the whole store back in order.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_HSK    = 2'd2,
    MODE_CONT   = 2'd3
  } adcMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BUSY,
    ST_WAIT,
    ST_PACE
  } seqState_e;

  // strobes from control to the sample store
  typedef struct packed {
    logic push;
    logic pushIrq;
    logic clear;
    logic pop;
  } bufStb_t;

endpackage

// File: rtl/adc_seq_ctrl_fsm.sv
module adc_seq_ctrl_fsm
  import adc_seq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int CNT_W   = 6,
  parameter int CH_NUM  = 14,
  parameter int CH_W    = 4,
  parameter int RATE_W  = 16,
  parameter int MIN_GAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [1:0]        modeSel,
  input  logic              setupWr,
  input  logic [CH_W-1:0]   setupChan,
  input  logic [CNT_W-1:0]  setupCount,
  input  logic [RATE_W-1:0] setupRate,
  input  logic              rdEn,
  input  logic              irqClr,
  input  logic              irqFlag,
  input  logic              convDone,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  output logic [1:0]        modeStatus,
  output logic [CNT_W-1:0]  countEff,
  output bufStb_t           bufStb
);

  adcMode_e          modeReg;
  seqState_e         state;
  logic [CH_W-1:0]   chanReg;
  logic [RATE_W-1:0] rateEff;
  logic [RATE_W-1:0] paceCnt;
  logic              paceOk, idleGo, paceGo, accept;

  // start conditions
  always_comb begin
    paceOk    = paceCnt >= RATE_W'(MIN_GAP);
    idleGo    = (state == ST_IDLE) && (modeReg != MODE_SLEEP) &&
                !((modeReg == MODE_HSK) && irqFlag);
    paceGo    = (state == ST_PACE) && (paceCnt >= rateEff);
    convStart = !modeWr && paceOk && (idleGo || paceGo);
    accept    = (state == ST_BUSY) && convDone && !modeWr;
  end

  always_comb begin
    bufStb.push    = accept;
    bufStb.pushIrq = accept && (modeReg == MODE_HSK);
    bufStb.clear   = irqClr;
    bufStb.pop     = rdEn;
  end

  assign convChan   = chanReg;
  assign modeStatus = modeReg;

  // sequencing state and mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_SLEEP;
      state   <= ST_IDLE;
    end else if (modeWr) begin
      modeReg <= adcMode_e'(modeSel);
      state   <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (convStart) state <= ST_BUSY;
        ST_BUSY: if (convDone) begin
          unique case (modeReg)
            MODE_SINGLE: begin
              modeReg <= MODE_SLEEP;
              state   <= ST_IDLE;
            end
            MODE_HSK:  state <= ST_WAIT;
            MODE_CONT: state <= ST_PACE;
            default:   state <= ST_IDLE;
          endcase
        end
        ST_WAIT: if (irqClr) state <= ST_IDLE;
        ST_PACE: if (convStart) state <= ST_BUSY;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // spacing counter, saturating; reset value lets the first start go at once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              paceCnt <= RATE_W'(MIN_GAP);
    else if (convStart)     paceCnt <= RATE_W'(1);
    else if (paceCnt != '1) paceCnt <= paceCnt + RATE_W'(1);
  end

  // setup fields, clamped when loaded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chanReg  <= '0;
      countEff <= CNT_W'(DEPTH);
      rateEff  <= RATE_W'(MIN_GAP);
    end else if (setupWr) begin
      chanReg  <= (setupChan > CH_W'(CH_NUM - 1)) ? CH_W'(CH_NUM - 1) : setupChan;
      countEff <= ((setupCount == '0) || (setupCount > CNT_W'(DEPTH))) ?
                  CNT_W'(DEPTH) : setupCount;
      rateEff  <= (setupRate < RATE_W'(MIN_GAP)) ? RATE_W'(MIN_GAP) : setupRate;
    end
  end

endmodule

// File: rtl/adc_seq_buf.sv
module adc_seq_buf
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WORD  = 16,
  parameter int CNT_W = 6,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  bufStb_t          bufStb,
  input  logic [WORD-1:0]  sampleIn,
  input  logic [CNT_W-1:0] countEff,
  output logic [WORD-1:0]  rdData,
  output logic [CNT_W-1:0] fillCount,
  output logic             irq,
  output logic             overflow
);

  logic [WORD-1:0]  mem [DEPTH];
  logic [IDX_W-1:0] wrQ, rdQ, wrB, rdB, wrN, rdN;
  logic [CNT_W-1:0] fillB, fillN;
  logic             irqB, irqN, ovfB, ovfN, full;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p,
                                            input logic [CNT_W-1:0] lim);
    if (CNT_W'(p) + CNT_W'(1) >= lim) return '0;
    return p + IDX_W'(1);
  endfunction

  always_comb begin
    // an acknowledge is applied first, a same-cycle sample lands afterwards
    fillB = bufStb.clear ? '0   : fillCount;
    wrB   = bufStb.clear ? '0   : wrQ;
    rdB   = bufStb.clear ? '0   : (bufStb.pop ? bump(rdQ, countEff) : rdQ);
    irqB  = bufStb.clear ? 1'b0 : irq;
    ovfB  = bufStb.clear ? 1'b0 : overflow;
    full  = fillB >= countEff;
    fillN = fillB;
    wrN   = wrB;
    rdN   = rdB;
    irqN  = irqB;
    ovfN  = ovfB;
    if (bufStb.push) begin
      wrN   = bump(wrB, countEff);
      fillN = full ? fillB : fillB + CNT_W'(1);
      rdN   = full ? bump(wrB, countEff) : rdB;
      ovfN  = ovfB | full;
      irqN  = irqB | bufStb.pushIrq | (fillN == countEff);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ       <= '0;
      rdQ       <= '0;
      fillCount <= '0;
      irq       <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      wrQ       <= wrN;
      rdQ       <= rdN;
      fillCount <= fillN;
      irq       <= irqN;
      overflow  <= ovfN;
    end
  end

  always_ff @(posedge clk) begin
    if (bufStb.push) mem[wrB] <= sampleIn;
  end

  assign rdData = mem[rdQ];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int WORD    = 16,
  parameter int RES     = 12,
  parameter int CH_NUM  = 14,
  parameter int RATE_W  = 16,
  parameter int MIN_GAP = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CH_W   = $clog2(CH_NUM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWr,
  input  logic [1:0]        modeSel,
  input  logic              setupWr,
  input  logic [CH_W-1:0]   setupChan,
  input  logic [CNT_W-1:0]  setupCount,
  input  logic [RATE_W-1:0] setupRate,
  input  logic              rdEn,
  input  logic              irqClr,
  output logic [WORD-1:0]   rdData,
  output logic [CNT_W-1:0]  fillCount,
  output logic              irq,
  output logic              overflow,
  output logic [1:0]        modeStatus,
  output logic              convStart,
  output logic [CH_W-1:0]   convChan,
  input  logic              convDone,
  input  logic [RES-1:0]    convResult
);

  bufStb_t          bufStb;
  logic [CNT_W-1:0] countEff;
  logic [WORD-1:0]  sampleWord;

  assign sampleWord = WORD'(convResult);

  adc_seq_ctrl_fsm #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .CH_NUM(CH_NUM), .CH_W(CH_W),
    .RATE_W(RATE_W), .MIN_GAP(MIN_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeSel(modeSel),
    .setupWr(setupWr), .setupChan(setupChan), .setupCount(setupCount),
    .setupRate(setupRate), .rdEn(rdEn), .irqClr(irqClr), .irqFlag(irq),
    .convDone(convDone), .convStart(convStart), .convChan(convChan),
    .modeStatus(modeStatus), .countEff(countEff), .bufStb(bufStb)
  );

  adc_seq_buf #(
    .DEPTH(DEPTH), .WORD(WORD), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_buf (
    .clk(clk), .rstN(rstN), .bufStb(bufStb), .sampleIn(sampleWord),
    .countEff(countEff), .rdData(rdData), .fillCount(fillCount),
    .irq(irq), .overflow(overflow)
  );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int DEPTH   = 32,
  parameter int WORD    = 16,
  parameter int RES     = 12,
  parameter int MIN_GAP = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int GAP_W  = $clog2(MIN_GAP + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeWr,
  input logic             irqClr,
  input logic             convStart,
  input logic             push,
  input logic [1:0]       modeStatus,
  input logic             irq,
  input logic             overflow,
  input logic [CNT_W-1:0] fillCount,
  input logic [WORD-1:0]  rdData
);

  logic [GAP_W-1:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceStart <= GAP_W'(MIN_GAP);
    else if (convStart)                     sinceStart <= GAP_W'(1);
    else if (sinceStart < GAP_W'(MIN_GAP))  sinceStart <= sinceStart + GAP_W'(1);
  end

  a_r1_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'd0) |-> !convStart);

  a_r2_single_to_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'd1 && push) |=> (modeStatus == 2'd0));

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'd2 && irq) |-> !convStart);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(|rdData[WORD-1:RES]));

  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (sinceStart >= GAP_W'(MIN_GAP)));

  a_r8_ack_empties: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !push) |=> (fillCount == '0 && !irq && !overflow));

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !irqClr) |=> overflow);

  a_r12_abort_discards: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !irqClr) |=> $stable(fillCount));

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .DEPTH(DEPTH), .WORD(WORD), .RES(RES), .MIN_GAP(MIN_GAP)
) u_chk (
  .clk(clk), .rstN(rstN), .modeWr(modeWr), .irqClr(irqClr),
  .convStart(convStart), .push(bufStb.push), .modeStatus(modeStatus),
  .irq(irq), .overflow(overflow), .fillCount(fillCount), .rdData(rdData)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int DEPTH = 32, RES = 12, CH_W = 4, CNT_W = 6, RATE_W = 16;

  logic clk = 1'b0, rstN = 1'b0;
  logic modeWr = 0, setupWr = 0, rdEn = 0, irqClr = 0;
  logic [1:0] modeSel = '0;
  logic [CH_W-1:0] setupChan = '0;
  logic [CNT_W-1:0] setupCount = '0;
  logic [RATE_W-1:0] setupRate = '0;
  logic [15:0] rdData;
  logic [CNT_W-1:0] fillCount;
  logic irq, overflow, convStart, convDone;
  logic [1:0] modeStatus;
  logic [CH_W-1:0] convChan;
  logic [RES-1:0] convResult;

  always #2.5 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rstN(rstN), .modeWr(modeWr), .modeSel(modeSel),
    .setupWr(setupWr), .setupChan(setupChan), .setupCount(setupCount),
    .setupRate(setupRate), .rdEn(rdEn), .irqClr(irqClr), .rdData(rdData),
    .fillCount(fillCount), .irq(irq), .overflow(overflow),
    .modeStatus(modeStatus), .convStart(convStart), .convChan(convChan),
    .convDone(convDone), .convResult(convResult)
  );

  // converter stub: 16 cycles from start to done
  logic [4:0] stubCnt = '0;
  logic [7:0] stubSeq = '0;
  logic [CH_W-1:0] stubChan = '0;
  always @(posedge clk) begin
    if (convStart) begin
      stubCnt  <= 5'd15;
      stubSeq  <= stubSeq + 8'd1;
      stubChan <= convChan;
    end else if (stubCnt != 0) stubCnt <= stubCnt - 5'd1;
  end
  assign convDone   = (stubCnt == 5'd1);
  assign convResult = {stubChan, stubSeq};

  int total = 0, bad = 0;
  int expCount = 32, expRate = 16, cyc = 0, lastStartCyc = -1, starts = 0;
  bit armed = 0, contCheck = 0;
  logic [CH_W-1:0] lastChan = '0;
  logic [RES-1:0] lastDone = '0;
  logic [RES-1:0] q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int effRate(int r); return (r < 16) ? 16 : r; endfunction
  function automatic int effCount(int c); return (c == 0 || c > DEPTH) ? DEPTH : c; endfunction
  function automatic int effChan(int c); return (c > 13) ? 13 : c; endfunction

  // monitor on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (convStart) begin
      if (contCheck && lastStartCyc >= 0)
        chk(cyc - lastStartCyc == expRate, "R4 start spacing", cyc - lastStartCyc, expRate);
      lastStartCyc = cyc;
      starts++;
      lastChan = convChan;
    end
    if (convDone) begin
      lastDone = convResult;
      if (armed) begin
        q.push_back(convResult);
        if (q.size() > expCount) void'(q.pop_front());
      end
    end
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic setMode(input int m);
    modeSel = m[1:0]; modeWr = 1; @(negedge clk); modeWr = 0;
    armed = (m != 0); contCheck = (m == 3); lastStartCyc = -1;
  endtask

  task automatic setup(input int ch, input int cnt, input int rate);
    setupChan = ch[CH_W-1:0]; setupCount = cnt[CNT_W-1:0]; setupRate = rate[RATE_W-1:0];
    setupWr = 1; @(negedge clk); setupWr = 0;
    expCount = effCount(cnt); expRate = effRate(rate);
  endtask

  task automatic clearIrq();
    irqClr = 1; @(negedge clk); irqClr = 0; q.delete();
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!convDone);
  endtask

  task automatic stopAfterDone();
    waitDone(); @(negedge clk); setMode(0);
  endtask

  task automatic readCheck(input string req);
    int n = q.size();
    for (int i = 0; i < n; i++) begin
      chk(int'(rdData) == int'(q[i]), req, int'(rdData), int'(q[i]));
      rdEn = 1; @(negedge clk); rdEn = 0;
    end
    if (n == expCount && n > 0)
      chk(int'(rdData) == int'(q[0]), "R11 read pointer wraps", int'(rdData), int'(q[0]));
    chk(int'(fillCount) == n, "R11 read keeps fill", int'(fillCount), n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, c0, rate, cnt, ch;
    void'($urandom(32'd4711));
    tick(4); rstN = 1; tick(1);
    // R1 reset values and quiet sleep
    chk(modeStatus == 0, "R1 mode status", modeStatus, 0);
    chk(irq == 0 && overflow == 0, "R1 flags", {irq, overflow}, 0);
    chk(fillCount == 0, "R1 fill", fillCount, 0);
    tick(40);
    chk(starts == 0, "R1 no start in sleep", starts, 0);

    // R6 default count of 32, default spacing 16
    setMode(3);
    while (!irq) @(negedge clk);
    chk(fillCount == 32, "R6 irq at default count", fillCount, 32);
    stopAfterDone();
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    chk(fillCount == 32, "R9 fill holds", fillCount, 32);
    readCheck("R9 oldest first after overwrite");
    clearIrq(); tick(1);
    chk(fillCount == 0 && irq == 0 && overflow == 0, "R8 ack empties", {fillCount, irq, overflow}, 0);

    // R2 single-shot, R5 alignment, R10 channel
    setup(5, 3, 16);
    for (int i = 0; i < 4; i++) begin
      s0 = starts;
      setMode(1); waitDone(); tick(2);
      chk(modeStatus == 0, "R2 back to sleep", modeStatus, 0);
      chk(starts - s0 == 1, "R2 one conversion", starts - s0, 1);
      chk(int'(fillCount) == ((i < 3) ? i + 1 : 3), "R6 fill count", fillCount, (i < 3) ? i + 1 : 3);
      chk(irq == (i >= 2), "R6 irq at count", irq, i >= 2);
      chk(lastChan == 5, "R10 channel", lastChan, 5);
      if (i == 0) chk(int'(rdData) == int'(q[0]), "R5 right aligned word", rdData, q[0]);
      if (i == 3) chk(overflow == 1, "R9 overflow single", overflow, 1);
    end
    s0 = starts; tick(40);
    chk(starts == s0, "R2 no restart", starts - s0, 0);
    readCheck("R11 single readout");
    clearIrq();

    // R12 abort in flight
    s0 = starts;
    setMode(1); tick(5); setMode(0); tick(30);
    chk(fillCount == 0, "R12 aborted sample dropped", fillCount, 0);
    chk(starts - s0 == 1 && modeStatus == 0, "R12 halted", starts - s0, 1);

    // R3 handshake, R10 clamp, spacing ignored
    setup(15, 8, 200);
    s0 = starts;
    setMode(2); tick(30);
    chk(starts - s0 == 1, "R3 first conversion", starts - s0, 1);
    chk(irq == 1 && fillCount == 1, "R3 irq per sample", {irq, fillCount}, 8'h41);
    chk(lastChan == 13, "R10 channel clamp", lastChan, 13);
    tick(60);
    chk(starts - s0 == 1, "R3 hold until ack", starts - s0, 1);
    c0 = cyc; clearIrq(); tick(30);
    chk(starts - s0 == 2, "R3 restart after ack", starts - s0, 2);
    chk(lastStartCyc - c0 < 5, "R3 restart not paced", lastStartCyc - c0, 2);
    chk(irq == 1 && fillCount == 1, "R3 second sample", {irq, fillCount}, 8'h41);
    readCheck("R5 handshake word");
    setMode(0); clearIrq();

    // R8 ack in the same cycle as a finishing sample
    setup(2, 4, 20);
    setMode(3); waitDone(); waitDone(); waitDone();
    irqClr = 1; @(negedge clk); irqClr = 0;
    q.delete(); q.push_back(lastDone);
    chk(fillCount == 1, "R8 same-cycle sample kept", fillCount, 1);
    chk(irq == 0 && overflow == 0, "R8 flags cleared", {irq, overflow}, 0);
    stopAfterDone();
    readCheck("R8 entries after ack");
    clearIrq();

    // R4/R7 seeded random free-running runs with overflow
    for (int it = 0; it < 4; it++) begin
      rate = (it == 0) ? 5 : 16 + int'($urandom % 48);
      cnt  = (it == 1) ? 40 : 2 + int'($urandom % 6);
      ch   = int'($urandom % 16);
      if (it == 1) rate = 16;
      setup(ch, cnt, rate);
      s0 = starts;
      setMode(3);
      while (starts - s0 < effCount(cnt) + 2) @(negedge clk);
      stopAfterDone();
      chk(overflow == 1, "R9 overflow continuous", overflow, 1);
      chk(int'(fillCount) == effCount(cnt), "R6 fill clamps to count", fillCount, effCount(cnt));
      chk(irq == 1, "R6 irq continuous", irq, 1);
      chk(int'(lastChan) == effChan(ch), "R10 channel random", lastChan, effChan(ch));
      readCheck("R9 random readout");
      clearIrq(); tick(1);
      chk(fillCount == 0, "R8 cleared after run", fillCount, 0);
      s0 = starts; tick(40);
      chk(starts == s0, "R4 stops on mode write", starts - s0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule